// File: doc/BRIEF.md
# Counter Overflow Status Register

This block keeps one sticky overflow flag for the cycle counter and one for each event counter, up to 31, of a performance monitoring unit. Each counter supplies two wrap pulses: one for an unsigned wrap of its low 32 bits and one for a wrap of its full 64 bits. Control bits choose per counter group which of the two pulses counts as an overflow. A flag stays set until software writes a 1 to its bit. Writing a 0 leaves the flag as it is.

A limit N decides how many event-counter bits software can see. When the hypervisor level is enabled and the access comes from one of the two lowest privilege levels, N is the hypervisor limit. Otherwise N is the base implemented-counter limit. Event bits at or above N read as zero, and writes to them have no effect. Those flags still record overflows, and they become visible again once N covers them. The status word and the pending summary are combinational views of the flags under the present limit. A write or an overflow changes the word one clock edge later.

All pins are plain level or single-cycle control signals. Reads have no handshake, and a write takes effect in the cycle it is asserted, so the block never applies back-pressure.

Top module: `ovs_status`

## Requirements
- R1: A synchronous reset (rst_n low at a rising edge) clears every flag, so rd_data reads 0 and ovf_pending is 0, even if wrap pulses are active in that cycle.
- R2: An accepted overflow pulse for event counter n sets rd_data[n] from the next edge on, when n < N. The flag stays 1 over later cycles until it is cleared.
- R3: On a write (wr_en high), each wr_data bit that is 1 clears its flag at the next edge. A wr_data bit that is 0 leaves its flag unchanged. Bit 31 is the cycle counter and bit n is event counter n.
- R4: If an accepted overflow pulse and a write-one clear hit the same flag in the same cycle, the flag reads 1 afterwards.
- R5: The cycle-counter flag, rd_data[31], takes its overflow from cyc_wrap_lo when cyc_long is 0 and from cyc_wrap_hi when cyc_long is 1. The other pulse is ignored.
- R6: Event counter n uses hyp_long as its width select when hyp_en is 1 and n >= hyp_limit. Otherwise it uses base_long. A select of 1 accepts evt_wrap_hi[n]; a select of 0 accepts evt_wrap_lo[n].
- R7: N equals hyp_limit when hyp_en and priv_low are both 1. Otherwise N equals base_limit.
- R8: Event bits n >= N read as 0, and a write of 1 to them does not clear the stored flag. That flag reads 1 again once N exceeds n.
- R9: An accepted overflow for an event counter with n >= N is still recorded, and it shows once N is raised above n.
- R10: ovf_pending is 1 exactly when rd_data is nonzero. That covers the cycle flag plus the event flags below N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hyp_en | input | 1 | Hypervisor level implemented and enabled |
| priv_low | input | 1 | Access comes from one of the two lowest privilege levels |
| hyp_limit | input | 5 | Hypervisor-set counter limit |
| base_limit | input | 5 | Base implemented-counter limit |
| cyc_long | input | 1 | Cycle counter uses the 64-bit wrap |
| base_long | input | 1 | Base-partition event counters use the 64-bit wrap |
| hyp_long | input | 1 | Hypervisor-partition event counters use the 64-bit wrap |
| cyc_wrap_lo | input | 1 | Cycle counter wrapped bits [31:0] |
| cyc_wrap_hi | input | 1 | Cycle counter wrapped bits [63:0] |
| evt_wrap_lo | input | NUM_EVT (31) | Per event counter wrap of bits [31:0] |
| evt_wrap_hi | input | NUM_EVT (31) | Per event counter wrap of bits [63:0] |
| wr_en | input | 1 | Write-one-to-clear strobe |
| wr_data | input | 32 | Clear mask |
| rd_data | output | 32 | Visible status word |
| ovf_pending | output | 1 | OR of all visible flags |

## Verification
The stimulus puts low and high wrap pulses on the same counters while the width selects change. This shows whether the right pulse is taken per counter group, and it separates the base partition from the hypervisor partition on each side of hyp_limit. Writes with zero bits, single-bit clears and a clear that collides with a set separate true write-one-to-clear behaviour from plain overwrite and from clear-wins priority. The limit is toggled through both of its sources while flags sit above it. This shows that hiding masks only the view and the write path, and that stored and newly arriving flags reappear once the limit is raised.

// File: rtl/ovs_pkg.sv
package ovs_pkg;
  localparam int REG_W   = 32;
  localparam int CYC_BIT = 31;
  localparam int MAX_EVT = 31;
  localparam int LIM_W   = $clog2(MAX_EVT + 1);
endpackage

// File: rtl/ovs_wrap_sel.sv
module ovs_wrap_sel
  import ovs_pkg::*;
#(
  parameter int NUM_EVT = 31
) (
  input  logic               hyp_en,
  input  logic [LIM_W-1:0]   hyp_limit,
  input  logic               cyc_long,
  input  logic               base_long,
  input  logic               hyp_long,
  input  logic               cyc_wrap_lo,
  input  logic               cyc_wrap_hi,
  input  logic [NUM_EVT-1:0] evt_wrap_lo,
  input  logic [NUM_EVT-1:0] evt_wrap_hi,
  output logic               cyc_set,
  output logic [NUM_EVT-1:0] evt_set
);
  assign cyc_set = cyc_long ? cyc_wrap_hi : cyc_wrap_lo;

  // Counters at or above the hypervisor limit form the hypervisor partition.
  for (genvar n = 0; n < NUM_EVT; n++) begin : g_sel
    logic in_hyp;
    logic use_long;
    assign in_hyp   = hyp_en && (LIM_W'(n) >= hyp_limit);
    assign use_long = in_hyp ? hyp_long : base_long;
    assign evt_set[n] = use_long ? evt_wrap_hi[n] : evt_wrap_lo[n];
  end
endmodule

// File: rtl/ovs_limit.sv
module ovs_limit
  import ovs_pkg::*;
#(
  parameter int NUM_EVT = 31
) (
  input  logic               hyp_en,
  input  logic               priv_low,
  input  logic [LIM_W-1:0]   hyp_limit,
  input  logic [LIM_W-1:0]   base_limit,
  output logic [NUM_EVT-1:0] vis_mask
);
  logic [LIM_W-1:0] eff_n;
  assign eff_n = (hyp_en && priv_low) ? hyp_limit : base_limit;

  for (genvar n = 0; n < NUM_EVT; n++) begin : g_mask
    assign vis_mask[n] = LIM_W'(n) < eff_n;
  end
endmodule

// File: rtl/ovs_flag_bank.sv
module ovs_flag_bank #(
  parameter int BITS = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [BITS-1:0] set,
  input  logic [BITS-1:0] clr,
  output logic [BITS-1:0] flags
);
  for (genvar b = 0; b < BITS; b++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)      flags[b] <= 1'b0;
      else if (set[b]) flags[b] <= 1'b1;  // set has priority over clear
      else if (clr[b]) flags[b] <= 1'b0;
    end
  end
endmodule

// File: rtl/ovs_status.sv
module ovs_status
  import ovs_pkg::*;
#(
  parameter int NUM_EVT = 31
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hyp_en,
  input  logic               priv_low,
  input  logic [LIM_W-1:0]   hyp_limit,
  input  logic [LIM_W-1:0]   base_limit,
  input  logic               cyc_long,
  input  logic               base_long,
  input  logic               hyp_long,
  input  logic               cyc_wrap_lo,
  input  logic               cyc_wrap_hi,
  input  logic [NUM_EVT-1:0] evt_wrap_lo,
  input  logic [NUM_EVT-1:0] evt_wrap_hi,
  input  logic               wr_en,
  input  logic [REG_W-1:0]   wr_data,
  output logic [REG_W-1:0]   rd_data,
  output logic               ovf_pending
);
  localparam int FLAG_W = NUM_EVT + 1;  // top flag is the cycle counter

  logic               cyc_set;
  logic [NUM_EVT-1:0] evt_set;
  logic [NUM_EVT-1:0] vis_mask;
  logic [FLAG_W-1:0]  set_vec;
  logic [FLAG_W-1:0]  clr_vec;
  logic [FLAG_W-1:0]  flags;
  logic [NUM_EVT-1:0] evt_vis;

  ovs_wrap_sel #(.NUM_EVT(NUM_EVT)) u_sel (
    .hyp_en      (hyp_en),
    .hyp_limit   (hyp_limit),
    .cyc_long    (cyc_long),
    .base_long   (base_long),
    .hyp_long    (hyp_long),
    .cyc_wrap_lo (cyc_wrap_lo),
    .cyc_wrap_hi (cyc_wrap_hi),
    .evt_wrap_lo (evt_wrap_lo),
    .evt_wrap_hi (evt_wrap_hi),
    .cyc_set     (cyc_set),
    .evt_set     (evt_set)
  );

  ovs_limit #(.NUM_EVT(NUM_EVT)) u_lim (
    .hyp_en     (hyp_en),
    .priv_low   (priv_low),
    .hyp_limit  (hyp_limit),
    .base_limit (base_limit),
    .vis_mask   (vis_mask)
  );

  // Hidden event bits ignore writes; the cycle bit is always writable.
  assign set_vec = {cyc_set, evt_set};
  assign clr_vec = {wr_en & wr_data[CYC_BIT],
                    {NUM_EVT{wr_en}} & wr_data[NUM_EVT-1:0] & vis_mask};

  ovs_flag_bank #(.BITS(FLAG_W)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (set_vec),
    .clr   (clr_vec),
    .flags (flags)
  );

  assign evt_vis = flags[NUM_EVT-1:0] & vis_mask;

  always_comb begin
    rd_data                = '0;
    rd_data[CYC_BIT]       = flags[NUM_EVT];
    rd_data[NUM_EVT-1:0]   = evt_vis;
  end

  assign ovf_pending = flags[NUM_EVT] | (|evt_vis);
endmodule

// File: rtl/ovs_status_chk.sv
module ovs_status_chk
  import ovs_pkg::*;
#(
  parameter int NUM_EVT = 31
) (
  input logic               clk,
  input logic               rst_n,
  input logic               hyp_en,
  input logic               priv_low,
  input logic [LIM_W-1:0]   hyp_limit,
  input logic [LIM_W-1:0]   base_limit,
  input logic               cyc_long,
  input logic               cyc_wrap_lo,
  input logic               cyc_wrap_hi,
  input logic               wr_en,
  input logic [REG_W-1:0]   wr_data,
  input logic [REG_W-1:0]   rd_data,
  input logic               ovf_pending
);
  logic               cyc_pulse;
  logic [LIM_W-1:0]   lim_n;
  logic [NUM_EVT-1:0] hidden;

  assign cyc_pulse = cyc_long ? cyc_wrap_hi : cyc_wrap_lo;
  assign lim_n     = (hyp_en && priv_low) ? hyp_limit : base_limit;

  always_comb begin
    for (int n = 0; n < NUM_EVT; n++) hidden[n] = (n >= int'(lim_n));
  end

  AST_CYC_SET: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_pulse |=> rd_data[CYC_BIT]);  // R5
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_pulse && wr_en && wr_data[CYC_BIT]) |=> rd_data[CYC_BIT]);  // R4
  AST_CYC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[CYC_BIT] && !cyc_pulse) |=> !rd_data[CYC_BIT]);  // R3
  AST_CYC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[CYC_BIT] && !(wr_en && wr_data[CYC_BIT])) |=> rd_data[CYC_BIT]);  // R2
  AST_HIDDEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[NUM_EVT-1:0] & hidden) == '0);  // R8
  AST_PENDING_OR: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pending == (rd_data != '0));  // R10
endmodule

bind ovs_status ovs_status_chk #(.NUM_EVT(NUM_EVT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hyp_en      (hyp_en),
  .priv_low    (priv_low),
  .hyp_limit   (hyp_limit),
  .base_limit  (base_limit),
  .cyc_long    (cyc_long),
  .cyc_wrap_lo (cyc_wrap_lo),
  .cyc_wrap_hi (cyc_wrap_hi),
  .wr_en       (wr_en),
  .wr_data     (wr_data),
  .rd_data     (rd_data),
  .ovf_pending (ovf_pending)
);

// File: tb/test_ovs_status.sv
module test_ovs_status;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        hyp_en, priv_low;
  logic [4:0]  hyp_limit, base_limit;
  logic        cyc_long, base_long, hyp_long;
  logic        cyc_wrap_lo, cyc_wrap_hi;
  logic [30:0] evt_wrap_lo, evt_wrap_hi;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        ovf_pending;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  ovs_status i_ovs_status (
    .clk(clk), .rst_n(rst_n), .hyp_en(hyp_en), .priv_low(priv_low),
    .hyp_limit(hyp_limit), .base_limit(base_limit), .cyc_long(cyc_long),
    .base_long(base_long), .hyp_long(hyp_long), .cyc_wrap_lo(cyc_wrap_lo),
    .cyc_wrap_hi(cyc_wrap_hi), .evt_wrap_lo(evt_wrap_lo),
    .evt_wrap_hi(evt_wrap_hi), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .ovf_pending(ovf_pending)
  );

  typedef struct packed {
    logic [63:0] tag;
    logic        hyp_en;
    logic        priv_low;
    logic [4:0]  hyp_lim;
    logic [4:0]  base_lim;
    logic        cyc_long;
    logic        base_long;
    logic        hyp_long;
    logic        cyc_lo;
    logic        cyc_hi;
    logic [30:0] evt_lo;
    logic [30:0] evt_hi;
    logic        wr;
    logic [31:0] wdata;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    // R2 R6: low wrap on counter 3 with 32-bit select sets it
    '{"R2 R6", 1'b0,1'b0,5'd31,5'd31, 1'b0,1'b0,1'b0, 1'b0,1'b0, 31'h8,31'h0, 1'b0,32'h0, 32'h8},
    // R6: high wrap ignored under 32-bit select; R2 flag 3 sticky
    '{"R2 R6", 1'b0,1'b0,5'd31,5'd31, 1'b0,1'b0,1'b0, 1'b0,1'b0, 31'h0,31'h20, 1'b0,32'h0, 32'h8},
    // R6: 64-bit select takes high wrap (5), drops low wrap (6)
    '{"R6", 1'b0,1'b0,5'd31,5'd31, 1'b0,1'b1,1'b0, 1'b0,1'b0, 31'h40,31'h20, 1'b0,32'h0, 32'h28},
    // R5: cycle low wrap under 32-bit select
    '{"R5", 1'b0,1'b0,5'd31,5'd31, 1'b0,1'b0,1'b0, 1'b1,1'b0, 31'h0,31'h0, 1'b0,32'h0, 32'h80000028},
    // R5 R3: low wrap ignored under 64-bit select; writing zeros changes nothing
    '{"R5 R3", 1'b0,1'b0,5'd31,5'd31, 1'b1,1'b0,1'b0, 1'b1,1'b0, 31'h0,31'h0, 1'b1,32'h0, 32'h80000028},
    // R3: single-bit clear
    '{"R3", 1'b0,1'b0,5'd31,5'd31, 1'b0,1'b0,1'b0, 1'b0,1'b0, 31'h0,31'h0, 1'b1,32'h8, 32'h80000020},
    // R4: set and clear on the cycle flag together, set wins
    '{"R4", 1'b0,1'b0,5'd31,5'd31, 1'b1,1'b0,1'b0, 1'b0,1'b1, 31'h0,31'h0, 1'b1,32'h80000000, 32'h80000020},
    // R3: clear all
    '{"R3", 1'b0,1'b0,5'd31,5'd31, 1'b0,1'b0,1'b0, 1'b0,1'b0, 31'h0,31'h0, 1'b1,32'hFFFFFFFF, 32'h0},
    // R6: partitions at hyp_limit 8: 2 low (base 32-bit), 10 low dropped, 12 high taken
    '{"R6", 1'b1,1'b0,5'd8,5'd31, 1'b0,1'b0,1'b1, 1'b0,1'b0, 31'h404,31'h1000, 1'b0,32'h0, 32'h1004},
    // R7 R8: low privilege gives N=8, bit 12 hidden
    '{"R7 R8", 1'b1,1'b1,5'd8,5'd31, 1'b0,1'b0,1'b0, 1'b0,1'b0, 31'h0,31'h0, 1'b0,32'h0, 32'h4},
    // R8: write all ones, hidden bit 12 keeps its flag
    '{"R8", 1'b1,1'b1,5'd8,5'd31, 1'b0,1'b0,1'b0, 1'b0,1'b0, 31'h0,31'h0, 1'b1,32'hFFFFFFFF, 32'h0},
    // R8 R7: higher privilege gives N=31, bit 12 reappears
    '{"R8 R7", 1'b1,1'b0,5'd8,5'd31, 1'b0,1'b0,1'b0, 1'b0,1'b0, 31'h0,31'h0, 1'b0,32'h0, 32'h1000},
    // R9 R10 R7: hyp off, base N=4, overflow on 20 hidden, nothing pending
    '{"R9 R10", 1'b0,1'b1,5'd31,5'd4, 1'b0,1'b0,1'b0, 1'b0,1'b0, 31'h100000,31'h0, 1'b0,32'h0, 32'h0},
    // R9: raising N reveals 20 and 12
    '{"R9", 1'b0,1'b1,5'd31,5'd31, 1'b0,1'b0,1'b0, 1'b0,1'b0, 31'h0,31'h0, 1'b0,32'h0, 32'h00101000},
    // R7: hyp on with low privilege takes hyp_limit 31 over base_limit 4
    '{"R7", 1'b1,1'b1,5'd31,5'd4, 1'b0,1'b0,1'b0, 1'b0,1'b0, 31'h0,31'h0, 1'b0,32'h0, 32'h00101000}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    cyc_wrap_lo = 1'b0; cyc_wrap_hi = 1'b0;
    evt_wrap_lo = '0;   evt_wrap_hi = '0;
    wr_en = 1'b0;       wr_data = '0;
  endtask

  initial begin
    rst_n = 1'b0; hyp_en = 1'b0; priv_low = 1'b0;
    hyp_limit = 5'd31; base_limit = 5'd31;
    cyc_long = 1'b0; base_long = 1'b0; hyp_long = 1'b0;
    idle_inputs();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: state after reset
    check("R1 rd_data", rd_data, 32'h0);
    check("R1 ovf_pending", {31'h0, ovf_pending}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      hyp_en      = VEC[i].hyp_en;   priv_low    = VEC[i].priv_low;
      hyp_limit   = VEC[i].hyp_lim;  base_limit  = VEC[i].base_lim;
      cyc_long    = VEC[i].cyc_long; base_long   = VEC[i].base_long;
      hyp_long    = VEC[i].hyp_long;
      cyc_wrap_lo = VEC[i].cyc_lo;   cyc_wrap_hi = VEC[i].cyc_hi;
      evt_wrap_lo = VEC[i].evt_lo;   evt_wrap_hi = VEC[i].evt_hi;
      wr_en       = VEC[i].wr;       wr_data     = VEC[i].wdata;
      @(posedge clk);
      @(negedge clk);
      check($sformatf("%s rd_data vec %0d", VEC[i].tag, i), rd_data, VEC[i].exp);
      check($sformatf("R10 ovf_pending vec %0d", i), {31'h0, ovf_pending},
            {31'h0, |VEC[i].exp});
    end

    // R1: reset while a cycle wrap is active still clears everything
    idle_inputs();
    cyc_long = 1'b0; cyc_wrap_lo = 1'b1; rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    idle_inputs();
    check("R1 rd_data mid-run", rd_data, 32'h0);
    check("R1 ovf_pending mid-run", {31'h0, ovf_pending}, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule